// File: doc/BRIEF.md
# Frame-Sync Serial Result Transmitter

This block sends a converter result to a host over three wires. The host supplies a continuous serial clock. The block supplies an active-low frame sync and a data line that it drives only while a frame is in flight. A separate enable output controls the pad's tri-state driver. Every register in the block runs on the serial clock. The end-of-conversion level and the convert-start line come from the converter core's own timing, so each passes through a synchroniser before its edge is detected.

A rising end-of-conversion level captures the result word into a one-entry hold register. The next free rising clock edge opens a frame and puts the most significant bit on the line. Each following rising edge presents the next lower bit, so the receiver can sample on falling edges. The data enable drops on the falling edge that follows the last data bit. The frame sync rises on the next rising edge after that.

If the host stops clocking before that final edge, the next falling edge of convert-start closes the frame. A result that arrives while a frame is being sent waits in the hold register until the frame has finished. The port keeps working while the core is powered down, which happens while convert-start is held low.

Top module: `frame_sync_tx`

## Requirements
- R1: After reset, frameSyncN is 1, dataOe is 0 and dataOut is 0.
- R2: Raise eocIn before rising edge P0. resultIn is captured at edge P(SYNC_STAGES), and resultIn must be stable from the rise until then. At edge P(SYNC_STAGES+1), frameSyncN goes to 0, dataOe goes to 1 and dataOut shows bit DATA_W-1. Before that edge, frameSyncN stays 1.
- R3: On each of the next DATA_W-1 rising edges, dataOut shows the next lower bit, ending with bit 0. frameSyncN stays 0 and dataOe stays 1 throughout.
- R4: dataOe returns to 0 on the falling edge that follows the rising edge presenting bit 0. frameSyncN is still 0 at that moment.
- R5: On the rising edge after the bit-0 edge, frameSyncN returns to 1 and dataOut reads 0.
- R6: Drive cnvStartN from 1 to 0 before rising edge P0. At edge P(SYNC_STAGES), any open frame ends: frameSyncN is 1, dataOe is 0 and dataOut is 0. No frame restarts unless a result is waiting.
- R7: A result whose eocIn rise lands during a frame is held, and it leaves the bits of the current frame unchanged. Its frame starts on the first rising edge after the current frame's frameSyncN has risen.
- R8: Holding cnvStartN at 0 (core powered down) has no effect on the start, the bit order or the end of a frame.
- R9: eocIn held high for many cycles produces exactly one frame.
- R10: With no rising edge on eocIn, frameSyncN stays 1 and dataOe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Continuous serial clock from the host |
| rstN | input | 1 | Asynchronous reset, active low |
| eocIn | input | 1 | End-of-conversion level from the core; a rise means a new result |
| resultIn | input | DATA_W | Conversion result that goes with eocIn |
| cnvStartN | input | 1 | Convert start, active low; its falling edge closes an open frame |
| frameSyncN | output | 1 | Receive frame sync, active low, idles high |
| dataOut | output | 1 | Serial data, most significant bit first, changed on rising edges |
| dataOe | output | 1 | Drive enable for the data pad's tri-state buffer |

## Verification
Each input passes through SYNC_STAGES synchroniser flops and then one edge-detect register. With the default of two stages, a frame opens on the fourth rising edge after eocIn rises, and an abort lands on the third rising edge after cnvStartN falls. Each data bit then follows exactly one rising edge after the one before. The bench counts these edges explicitly and reads the outputs two time units after each rising edge. The one output that changes on a falling edge, dataOe, is read one unit after the falling edge that follows the eighth bit. The mid-frame case gives the second result's rise time to pass the synchroniser before the first frame ends, then expects the second frame on the edge straight after frameSyncN rises.

// File: rtl/frame_sync_tx_pkg.sv
package frame_sync_tx_pkg;

  // Strobes issued by the control unit to the datapath for one clock
  typedef struct packed {
    logic capture;     // take resultIn into the hold register
    logic loadShift;   // move the held word into the shifter (frame start)
    logic shiftOn;     // advance the shifter by one bit
    logic clearShift;  // empty the shifter (abort)
  } ctlStrb_t;

endpackage

// File: rtl/frame_sync_tx_sync.sv
module frame_sync_tx_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic sclk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge sclk or negedge rstN) begin
        if (!rstN) pipe <= RST_VAL;
        else       pipe <= asyncIn;
      end
    end else begin : g_chain
      always_ff @(posedge sclk or negedge rstN) begin
        if (!rstN) pipe <= {STAGES{RST_VAL}};
        else       pipe <= {pipe[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/frame_sync_tx_ctrl.sv
module frame_sync_tx_ctrl
  import frame_sync_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     sclk,
  input  logic     rstN,
  input  logic     eocSync,
  input  logic     cnvSync,
  output ctlStrb_t strb,
  output logic     frameSyncN,
  output logic     dataOe
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

  logic eocPrev, cnvPrev;
  logic pendFlag, inFrame, enOn, doneNeg;
  logic [CNT_W-1:0] bitCnt;
  logic eocEvt, abortEvt, lastBit, startEvt;

  assign eocEvt   = eocSync & ~eocPrev;
  assign abortEvt = ~cnvSync & cnvPrev;
  assign lastBit  = inFrame && (bitCnt == LAST_CNT);
  assign startEvt = !abortEvt && !inFrame && pendFlag;

  always_comb begin
    strb.capture    = eocEvt;
    strb.loadShift  = startEvt;
    strb.shiftOn    = inFrame & ~abortEvt;
    strb.clearShift = abortEvt;
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      eocPrev    <= 1'b0;
      cnvPrev    <= 1'b1;
      pendFlag   <= 1'b0;
      inFrame    <= 1'b0;
      enOn       <= 1'b0;
      bitCnt     <= '0;
      frameSyncN <= 1'b1;
    end else begin
      eocPrev <= eocSync;
      cnvPrev <= cnvSync;

      if (eocEvt)        pendFlag <= 1'b1;
      else if (startEvt) pendFlag <= 1'b0;

      if (abortEvt || lastBit) begin
        inFrame    <= 1'b0;
        enOn       <= 1'b0;
        bitCnt     <= '0;
        frameSyncN <= 1'b1;
      end else if (inFrame) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end else if (pendFlag) begin
        inFrame    <= 1'b1;
        enOn       <= 1'b1;
        bitCnt     <= CNT_W'(1);
        frameSyncN <= 1'b0;
      end
    end
  end

  // Falling-edge flag so the pad is released half a clock after the last bit
  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN) doneNeg <= 1'b0;
    else       doneNeg <= lastBit;
  end

  assign dataOe = enOn & ~doneNeg;

endmodule

// File: rtl/frame_sync_tx_dp.sv
module frame_sync_tx_dp
  import frame_sync_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              sclk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [DATA_W-1:0] resultIn,
  output logic              dataOut
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN)             holdReg <= '0;
    else if (strb.capture) holdReg <= resultIn;
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strb.clearShift) shiftReg <= '0;
    else if (strb.loadShift)  shiftReg <= holdReg;
    else if (strb.shiftOn)    shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
  end

  assign dataOut = shiftReg[DATA_W-1];

endmodule

// File: rtl/frame_sync_tx.sv
module frame_sync_tx
  import frame_sync_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sclk,
  input  logic              rstN,
  input  logic              eocIn,
  input  logic [DATA_W-1:0] resultIn,
  input  logic              cnvStartN,
  output logic              frameSyncN,
  output logic              dataOut,
  output logic              dataOe
);

  logic     eocSync;
  logic     cnvSync;
  ctlStrb_t ctlStrb;

  frame_sync_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) eocSync_i (
    .sclk(sclk), .rstN(rstN), .asyncIn(eocIn), .syncOut(eocSync)
  );

  frame_sync_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) cnvSync_i (
    .sclk(sclk), .rstN(rstN), .asyncIn(cnvStartN), .syncOut(cnvSync)
  );

  frame_sync_tx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .sclk(sclk), .rstN(rstN), .eocSync(eocSync), .cnvSync(cnvSync),
    .strb(ctlStrb), .frameSyncN(frameSyncN), .dataOe(dataOe)
  );

  frame_sync_tx_dp #(.DATA_W(DATA_W)) dp_i (
    .sclk(sclk), .rstN(rstN), .strb(ctlStrb), .resultIn(resultIn),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/frame_sync_tx_chk.sv
module frame_sync_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic sclk,
  input logic rstN,
  input logic frameSyncN,
  input logic dataOe,
  input logic loadStb,
  input logic clearStb
);

  localparam int RUN_W = $clog2(DATA_W + 2);

  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN)           lowRun <= '0;
    else if (frameSyncN) lowRun <= '0;
    else                 lowRun <= lowRun + RUN_W'(1);
  end

  // R2: the edge that drops frame sync also enables the data pad
  a_r2_start_enables: assert property (@(posedge sclk) disable iff (!rstN)
    $fell(frameSyncN) |-> dataOe);

  // R3: a frame start leaves the frame open with the pad driven
  a_r3_load_opens: assert property (@(posedge sclk) disable iff (!rstN)
    loadStb |=> (!frameSyncN && dataOe));

  // R4: the pad is never driven outside a frame
  a_r4_oe_in_frame: assert property (@(posedge sclk) disable iff (!rstN)
    dataOe |-> !frameSyncN);

  // R5: frame sync is never low for more than DATA_W sampled edges
  a_r5_frame_bounded: assert property (@(posedge sclk) disable iff (!rstN)
    !frameSyncN |-> (lowRun < RUN_W'(DATA_W)));

  // R6: an abort closes the frame and releases the pad
  a_r6_abort_closes: assert property (@(posedge sclk) disable iff (!rstN)
    clearStb |=> (frameSyncN && !dataOe));

endmodule

bind frame_sync_tx frame_sync_tx_chk #(.DATA_W(DATA_W)) chk_i (
  .sclk(sclk),
  .rstN(rstN),
  .frameSyncN(frameSyncN),
  .dataOe(dataOe),
  .loadStb(ctlStrb.loadShift),
  .clearStb(ctlStrb.clearShift)
);

// File: tb/frame_sync_tx_tb_top.sv
module frame_sync_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int SYNC       = 2;

  logic sclk = 1'b0;
  logic rstN = 1'b0;
  logic eocIn = 1'b0;
  logic [DATA_W-1:0] resultIn = '0;
  logic cnvStartN = 1'b1;
  logic frameSyncN, dataOut, dataOe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) sclk = ~sclk;

  frame_sync_tx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) dut_i (
    .sclk(sclk), .rstN(rstN), .eocIn(eocIn), .resultIn(resultIn),
    .cnvStartN(cnvStartN), .frameSyncN(frameSyncN), .dataOut(dataOut),
    .dataOe(dataOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic idleCycles(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(posedge sclk); #2;
      check(req, {6'b0, frameSyncN, dataOe}, 8'b0000_0010);
    end
  endtask

  // Raise eocIn, confirm no frame before edge P(SYNC+1)
  task automatic armFrame(input logic [7:0] v, input bit keepHigh);
    eocIn = 1'b1; resultIn = v;
    for (int k = 0; k <= SYNC; k++) begin
      @(posedge sclk); #2;
      check("R2", {7'b0, frameSyncN}, 8'd1);
      if (k == 0 && !keepHigh) eocIn = 1'b0;
    end
  endtask

  // Eight bits MSB first, pad release on falling edge, sync rise after
  task automatic expectFrame(input logic [7:0] v, input string tag);
    for (int i = 0; i < DATA_W; i++) begin
      @(posedge sclk); #2;
      check(tag != "" ? tag : (i == 0 ? "R2" : "R3"),
            {5'b0, frameSyncN, dataOe, dataOut}, {5'b0, 1'b0, 1'b1, v[7-i]});
    end
    @(negedge sclk); #1;
    check(tag != "" ? tag : "R4", {6'b0, frameSyncN, dataOe}, 8'b0);
    @(posedge sclk); #2;
    check(tag != "" ? tag : "R5", {5'b0, frameSyncN, dataOe, dataOut}, 8'b0000_0100);
  endtask

  task automatic t_reset();
    check("R1", {5'b0, frameSyncN, dataOe, dataOut}, 8'b0000_0100);
    idleCycles(5, "R10");
  endtask

  task automatic t_frame(input logic [7:0] v);
    armFrame(v, 1'b0);
    expectFrame(v, "");
    idleCycles(3, "R10");
  endtask

  task automatic t_midFrame(input logic [7:0] v1, input logic [7:0] v2);
    eocIn = 1'b1; resultIn = v1;
    for (int k = 0; k <= SYNC; k++) begin
      @(posedge sclk); #2;
    end
    for (int i = 0; i < DATA_W; i++) begin
      @(posedge sclk); #2;
      check("R7", {5'b0, frameSyncN, dataOe, dataOut}, {5'b0, 1'b0, 1'b1, v1[7-i]});
      if (i == 0) eocIn = 1'b0;
      if (i == 4) begin eocIn = 1'b1; resultIn = v2; end
    end
    @(negedge sclk); #1;
    check("R7", {6'b0, frameSyncN, dataOe}, 8'b0);
    @(posedge sclk); #2;
    check("R7", {7'b0, frameSyncN}, 8'd1);
    eocIn = 1'b0;
    expectFrame(v2, "R7");
    idleCycles(3, "R7");
  endtask

  task automatic t_abort(input logic [7:0] v);
    armFrame(v, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(posedge sclk); #2;
      check("R3", {7'b0, dataOut}, {7'b0, v[7-i]});
    end
    cnvStartN = 1'b0;
    for (int k = 0; k < SYNC; k++) begin
      @(posedge sclk); #2;
      check("R6", {6'b0, frameSyncN, dataOut}, {6'b0, 1'b0, v[3-k]});
    end
    @(posedge sclk); #2;
    check("R6", {5'b0, frameSyncN, dataOe, dataOut}, 8'b0000_0100);
    cnvStartN = 1'b1;
    idleCycles(10, "R6");
  endtask

  task automatic t_powerDown(input logic [7:0] v);
    cnvStartN = 1'b0;
    idleCycles(5, "R8");
    armFrame(v, 1'b0);
    expectFrame(v, "R8");
    idleCycles(2, "R8");
    cnvStartN = 1'b1;
    idleCycles(3, "R8");
  endtask

  task automatic t_levelHold(input logic [7:0] v);
    armFrame(v, 1'b1);
    expectFrame(v, "");
    idleCycles(8, "R9");
    eocIn = 1'b0;
    idleCycles(4, "R9");
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge sclk);
    #2 rstN = 1'b1;
    t_reset();
    t_frame(8'hA5);
    t_frame(8'h3C);
    t_frame(8'hFF);
    t_frame(8'h00);
    t_frame(8'h81);
    t_midFrame(8'hC3, 8'h5A);
    t_abort(8'hB6);
    t_powerDown(8'h69);
    t_levelHold(8'h1E);
    finish();
  end

endmodule